// File: doc/BRIEF.md
# ADC Window Alarm with Hysteresis

This block watches 12-bit conversion results for three monitored channels (two analog inputs and a temperature sensor). Each result arrives with a channel index and a one-cycle valid strobe. The block compares the result against that channel's high and low limits. It trips a channel only after a programmable run of consecutive out-of-window results. Once tripped, the channel releases only when a later result is back inside the window by a programmable hysteresis margin.

A trip sets a sticky per-channel fault flag. A status-read strobe clears a flag, but only for a channel that is no longer tripped. A single interrupt output is the OR of the flags whose mask bit is 0. The threshold, hysteresis, fault-count and mask values come in as plain inputs from registers outside the block. Those registers are expected to reset to a high limit of FFh, a low limit of 00h, a hysteresis of 8 codes and masks of 1.

Each channel runs its own three-state machine:
- `CH_IDLE` goes to `CH_COUNT` on the first out-of-window result, or straight to `CH_TRIPPED` when the fault count is 0.
- `CH_COUNT` goes to `CH_TRIPPED` when the run is complete. It goes back to `CH_IDLE` on any in-window result.
- `CH_TRIPPED` goes to `CH_IDLE` on a result inside the hysteresis band.
- Every other case holds the current state.

Top module: `adc_window_alarm`

## Requirements
- R1: For channel c the high limit is {hi_thr[8c+7:8c], 4'b1111}. A result strictly above it is out of window. A result equal to it is not.
- R2: For channel c the low limit is {lo_thr[8c+7:8c], 4'b0000}. A result strictly below it is out of window. A result equal to it is not.
- R3: A channel trips after fault_cnt+1 consecutive out-of-window results for that channel, so 1 to 8 results for fault_cnt 0 to 7.
- R4: Before a trip, an in-window result for a channel resets that channel's run to zero.
- R5: A result affects only the channel named by res_chan (0, 1 or 2); res_chan = 3 affects no channel. Without a valid result or a status read, no flag changes.
- R6: A tripped channel releases only on a result r with r <= high limit − hyst and r >= low limit + hyst. A result inside the window but outside this band keeps it tripped.
- R7: fault_flag[c] goes to 1 at the clock edge that samples the result completing the trip.
- R8: fault_flag[c] is sticky. A status read clears it only if the channel is not tripped before that edge. A trip in the same cycle as a read leaves the flag at 1.
- R9: irq is 1 exactly when some fault_flag[c] is 1 while mask[c] is 0. A mask bit of 1 hides that channel from irq.
- R10: After reset all flags and irq are 0, and every channel is idle with an empty run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_valid | input | 1 | Conversion result valid strobe |
| res_chan | input | 2 | Channel index of the result |
| res_data | input | 12 | Conversion result |
| hi_thr | input | 24 | High thresholds, channel c in bits [8c+7:8c] |
| lo_thr | input | 24 | Low thresholds, channel c in bits [8c+7:8c] |
| hyst | input | 7 | Hysteresis in codes |
| fault_cnt | input | 3 | Consecutive faults needed, minus one |
| mask | input | 3 | Per-channel interrupt mask, 1 hides |
| status_rd | input | 1 | Status read strobe |
| fault_flag | output | 3 | Sticky per-channel fault flags |
| irq | output | 1 | OR of unmasked fault flags |

## Verification
The assertions assume the following about the inputs:
- res_valid and status_rd are single-cycle strobes that are 0 during reset.
- The thresholds, hysteresis and fault count stay steady from one result to the next.

The stimulus meets these assumptions. It changes configuration only between results, one cycle after a clock edge, and it raises each strobe for exactly one cycle. A behavioural model in the bench tracks each channel's run, trip state and flag, and the bench compares flags and irq against it on every falling clock edge.

// File: rtl/adc_win_pkg.sv
`timescale 1ns/1ps
package adc_win_pkg;
    typedef enum logic [1:0] {
        CH_IDLE    = 2'd0,
        CH_COUNT   = 2'd1,
        CH_TRIPPED = 2'd2
    } win_state_e;
endpackage

// File: rtl/adc_win_cmp.sv
`timescale 1ns/1ps
module adc_win_cmp #(
    parameter int DW = 12,
    parameter int TW = 8,
    parameter int HW = 7
) (
    input  logic [DW-1:0] data,
    input  logic [TW-1:0] hi,
    input  logic [TW-1:0] lo,
    input  logic [HW-1:0] hyst,
    output logic          out_win,
    output logic          in_band
);
    localparam int PAD = DW - TW;
    localparam int EW  = DW + 2;

    logic [DW-1:0]        hi_ext;
    logic [DW-1:0]        lo_ext;
    logic signed [EW-1:0] d_s;
    logic signed [EW-1:0] hi_rel;
    logic signed [EW-1:0] lo_rel;
    logic signed [EW-1:0] hy_s;

    always_comb begin
        hi_ext  = {hi, {PAD{1'b1}}};
        lo_ext  = {lo, {PAD{1'b0}}};
        out_win = (data > hi_ext) || (data < lo_ext);
        d_s     = $signed({2'b00, data});
        hy_s    = $signed({{(EW-HW){1'b0}}, hyst});
        hi_rel  = $signed({2'b00, hi_ext}) - hy_s;
        lo_rel  = $signed({2'b00, lo_ext}) + hy_s;
        in_band = (d_s <= hi_rel) && (d_s >= lo_rel);
    end
endmodule

// File: rtl/adc_win_chan.sv
`timescale 1ns/1ps
module adc_win_chan
    import adc_win_pkg::*;
#(
    parameter int DW = 12,
    parameter int TW = 8,
    parameter int HW = 7,
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic [DW-1:0] data,
    input  logic [TW-1:0] hi,
    input  logic [TW-1:0] lo,
    input  logic [HW-1:0] hyst,
    input  logic [CW-1:0] fcnt,
    input  logic          rd,
    output logic          flag_o
);
    win_state_e    state, state_n;
    logic [CW-1:0] run, run_n;
    logic          flag, flag_n;
    logic          trip;
    logic          out_win, in_band;

    adc_win_cmp #(.DW(DW), .TW(TW), .HW(HW)) i_cmp (
        .data    (data),
        .hi      (hi),
        .lo      (lo),
        .hyst    (hyst),
        .out_win (out_win),
        .in_band (in_band)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_IDLE;
            run   <= '0;
            flag  <= 1'b0;
        end else begin
            state <= state_n;
            run   <= run_n;
            flag  <= flag_n;
        end
    end

    // next state
    always_comb begin
        state_n = state;
        run_n   = run;
        trip    = 1'b0;
        unique case (state)
            CH_IDLE: begin
                if (hit && out_win) begin
                    if (fcnt == '0) begin
                        state_n = CH_TRIPPED;
                        trip    = 1'b1;
                    end else begin
                        state_n = CH_COUNT;
                        run_n   = CW'(1);
                    end
                end
            end
            CH_COUNT: begin
                if (hit) begin
                    if (!out_win) begin
                        state_n = CH_IDLE;
                        run_n   = '0;
                    end else if (run >= fcnt) begin
                        state_n = CH_TRIPPED;
                        run_n   = '0;
                        trip    = 1'b1;
                    end else begin
                        run_n = run + 1'b1;
                    end
                end
            end
            CH_TRIPPED: begin
                if (hit && in_band) begin
                    state_n = CH_IDLE;
                    run_n   = '0;
                end
            end
            default: begin
                state_n = CH_IDLE;
                run_n   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        flag_n = flag;
        if (trip)
            flag_n = 1'b1;
        else if (rd && (state != CH_TRIPPED))
            flag_n = 1'b0;
        flag_o = flag;
    end
endmodule

// File: rtl/adc_window_alarm.sv
`timescale 1ns/1ps
module adc_window_alarm #(
    parameter int NCH = 3,
    parameter int DW  = 12,
    parameter int TW  = 8,
    parameter int HW  = 7,
    parameter int CW  = 3,
    parameter int IW  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [IW-1:0]     res_chan,
    input  logic [DW-1:0]     res_data,
    input  logic [NCH*TW-1:0] hi_thr,
    input  logic [NCH*TW-1:0] lo_thr,
    input  logic [HW-1:0]     hyst,
    input  logic [CW-1:0]     fault_cnt,
    input  logic [NCH-1:0]    mask,
    input  logic              status_rd,
    output logic [NCH-1:0]    fault_flag,
    output logic              irq
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit = res_valid && (res_chan == IW'(g));
        adc_win_chan #(.DW(DW), .TW(TW), .HW(HW), .CW(CW)) i_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit    (hit),
            .data   (res_data),
            .hi     (hi_thr[g*TW +: TW]),
            .lo     (lo_thr[g*TW +: TW]),
            .hyst   (hyst),
            .fcnt   (fault_cnt),
            .rd     (status_rd),
            .flag_o (fault_flag[g])
        );
    end

    assign irq = |(fault_flag & ~mask);
endmodule

// File: rtl/adc_win_chk.sv
`timescale 1ns/1ps
module adc_win_chk #(
    parameter int NCH = 3,
    parameter int DW  = 12,
    parameter int TW  = 8,
    parameter int HW  = 7,
    parameter int CW  = 3,
    parameter int IW  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              res_valid,
    input logic [IW-1:0]     res_chan,
    input logic [DW-1:0]     res_data,
    input logic [NCH*TW-1:0] hi_thr,
    input logic [NCH*TW-1:0] lo_thr,
    input logic [HW-1:0]     hyst,
    input logic [CW-1:0]     fault_cnt,
    input logic [NCH-1:0]    mask,
    input logic              status_rd,
    input logic [NCH-1:0]    fault_flag,
    input logic              irq
);
    localparam int PAD = DW - TW;

    // R9
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq);

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|fault_flag));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(res_valid) && !$past(status_rd)) |-> $stable(fault_flag));

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R7
        flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(fault_flag[g]) |-> $past(res_valid && (res_chan == IW'(g))));

        // R8
        flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(fault_flag[g]) |-> $past(status_rd));

        // R1
        hi_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(res_valid && (res_chan == IW'(g)) && (fault_cnt == '0) &&
                  (res_data > {hi_thr[g*TW +: TW], {PAD{1'b1}}}))
            |-> fault_flag[g]);
    end
endmodule

bind adc_window_alarm adc_win_chk #(
    .NCH(NCH), .DW(DW), .TW(TW), .HW(HW), .CW(CW), .IW(IW)
) i_chk (.*);

// File: tb/test_adc_window_alarm.sv
`timescale 1ns/1ps
module test_adc_window_alarm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [1:0]  res_chan = '0;
    logic [11:0] res_data = '0;
    logic [23:0] hi_thr = 24'hFFFFFF;
    logic [23:0] lo_thr = 24'h000000;
    logic [6:0]  hyst = 7'd8;
    logic [2:0]  fault_cnt = 3'd0;
    logic [2:0]  mask = 3'b000;
    logic        status_rd = 1'b0;
    logic [2:0]  fault_flag;
    logic        irq;

    int    nchk = 0;
    int    nerr = 0;
    string cur_req = "R10";
    bit    done = 1'b0;

    int m_run   [3];
    bit m_alarm [3];
    bit m_flag  [3];

    always #2 clk = ~clk;

    adc_window_alarm i_adc_window_alarm (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
        .res_data(res_data), .hi_thr(hi_thr), .lo_thr(lo_thr), .hyst(hyst),
        .fault_cnt(fault_cnt), .mask(mask), .status_rd(status_rd),
        .fault_flag(fault_flag), .irq(irq)
    );

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 3; c++) begin
                m_run[c] = 0; m_alarm[c] = 0; m_flag[c] = 0;
            end
        end else begin
            for (int c = 0; c < 3; c++) begin
                bit was_alarm, tripped;
                int hl, ll, d;
                was_alarm = m_alarm[c];
                tripped   = 0;
                hl = int'(hi_thr[8*c +: 8]) * 16 + 15;
                ll = int'(lo_thr[8*c +: 8]) * 16;
                d  = int'(res_data);
                if (res_valid && int'(res_chan) == c) begin
                    if (m_alarm[c]) begin
                        if (d <= hl - int'(hyst) && d >= ll + int'(hyst)) begin
                            m_alarm[c] = 0; m_run[c] = 0;
                        end
                    end else if (d > hl || d < ll) begin
                        m_run[c] = m_run[c] + 1;
                        if (m_run[c] >= int'(fault_cnt) + 1) begin
                            m_alarm[c] = 1; m_run[c] = 0; tripped = 1;
                        end
                    end else begin
                        m_run[c] = 0;
                    end
                end
                if (tripped) m_flag[c] = 1;
                else if (status_rd && !was_alarm) m_flag[c] = 0;
            end
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [2:0] ef;
            logic       ei;
            ef = {m_flag[2], m_flag[1], m_flag[0]};
            ei = |(ef & ~mask);
            nchk++;
            if (fault_flag !== ef || irq !== ei) begin
                nerr++;
                $display("FAIL %s model: flags=%b irq=%b expected flags=%b irq=%b",
                         cur_req, fault_flag, irq, ef, ei);
            end
        end
    end

    task automatic send(input int ch, input int d);
        @(posedge clk); #1;
        res_valid = 1'b1; res_chan = 2'(ch); res_data = 12'(d);
        @(posedge clk); #1;
        res_valid = 1'b0;
    endtask

    task automatic read_st();
        @(posedge clk); #1; status_rd = 1'b1;
        @(posedge clk); #1; status_rd = 1'b0;
    endtask

    task automatic send_rd(input int ch, input int d);
        @(posedge clk); #1;
        res_valid = 1'b1; res_chan = 2'(ch); res_data = 12'(d); status_rd = 1'b1;
        @(posedge clk); #1;
        res_valid = 1'b0; status_rd = 1'b0;
    endtask

    task automatic exp_flag(input int ch, input bit e, input string tag);
        @(negedge clk);
        nchk++;
        if (fault_flag[ch] !== e) begin
            nerr++;
            $display("FAIL %s ch%0d flag=%b expected %b", tag, ch, fault_flag[ch], e);
        end
    endtask

    task automatic exp_irq(input bit e, input string tag);
        @(negedge clk);
        nchk++;
        if (irq !== e) begin
            nerr++;
            $display("FAIL %s irq=%b expected %b", tag, irq, e);
        end
    endtask

    task automatic recover(input int ch);
        send(ch, 12'h400);
        read_st();
    endtask

    initial begin
        #1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10 reset state
        exp_flag(0, 0, "R10"); exp_flag(1, 0, "R10"); exp_flag(2, 0, "R10");
        exp_irq(0, "R10");

        // R1 high limit, equal vs above
        cur_req = "R1"; hi_thr[7:0] = 8'h80;
        send(0, 12'h80F); exp_flag(0, 0, "R1");
        send(0, 12'h810); exp_flag(0, 1, "R1"); exp_irq(1, "R1");
        recover(0); exp_flag(0, 0, "R1");

        // R2 low limit, equal vs below
        cur_req = "R2"; lo_thr[15:8] = 8'h10;
        send(1, 12'h100); exp_flag(1, 0, "R2");
        send(1, 12'h0FF); exp_flag(1, 1, "R2");
        recover(1); exp_flag(1, 0, "R2");

        // R3 run length
        cur_req = "R3"; fault_cnt = 3'd3; hi_thr[23:16] = 8'h80;
        for (int i = 0; i < 3; i++) send(2, 12'h900);
        exp_flag(2, 0, "R3");
        send(2, 12'h900); exp_flag(2, 1, "R3");
        recover(2); exp_flag(2, 0, "R3");
        fault_cnt = 3'd7;
        for (int i = 0; i < 7; i++) send(0, 12'hA00);
        exp_flag(0, 0, "R3");
        send(0, 12'hA00); exp_flag(0, 1, "R3");
        recover(0);

        // R4 in-window result breaks the run
        cur_req = "R4"; fault_cnt = 3'd2;
        send(0, 12'h900); send(0, 12'h900); send(0, 12'h400);
        send(0, 12'h900); send(0, 12'h900);
        exp_flag(0, 0, "R4");
        send(0, 12'h900); exp_flag(0, 1, "R4");
        recover(0);

        // R5 channel isolation
        cur_req = "R5"; fault_cnt = 3'd1;
        send(0, 12'h900); send(3, 12'hFFF); send(1, 12'h900);
        exp_flag(0, 0, "R5"); exp_flag(1, 0, "R5"); exp_flag(2, 0, "R5");
        send(0, 12'h900); exp_flag(0, 1, "R5");
        recover(0);

        // R6 hysteresis release, both sides
        cur_req = "R6"; fault_cnt = 3'd0; hyst = 7'd16; lo_thr[7:0] = 8'h10;
        send(0, 12'h900); send(0, 12'h805); read_st(); exp_flag(0, 1, "R6");
        send(0, 12'h7FF); read_st(); exp_flag(0, 0, "R6");
        send(0, 12'h050); send(0, 12'h10F); read_st(); exp_flag(0, 1, "R6");
        send(0, 12'h110); read_st(); exp_flag(0, 0, "R6");

        // R8 sticky flag and read rules
        cur_req = "R8"; hyst = 7'd8; hi_thr[15:8] = 8'h80;
        send(1, 12'h900); read_st(); exp_flag(1, 1, "R8");
        send(1, 12'h400); exp_flag(1, 1, "R8");
        read_st(); exp_flag(1, 0, "R8");
        send_rd(1, 12'h900); exp_flag(1, 1, "R8");

        // R7 flag appears right after the tripping edge
        cur_req = "R7";
        @(posedge clk); #1; res_valid = 1'b1; res_chan = 2'd2; res_data = 12'hFFF;
        @(negedge clk); nchk++;
        if (fault_flag[2] !== 1'b0) begin
            nerr++; $display("FAIL R7 early flag=%b expected 0", fault_flag[2]);
        end
        @(posedge clk); #1; res_valid = 1'b0;
        exp_flag(2, 1, "R7");

        // R9 masking
        cur_req = "R9"; recover(2);
        mask = 3'b010; exp_irq(0, "R9");
        mask = 3'b101; exp_irq(1, "R9");
        mask = 3'b000; exp_irq(1, "R9");

        // R10 reset while flagged
        cur_req = "R10";
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        exp_flag(1, 0, "R10"); exp_irq(0, "R10");
        send(1, 12'h900); exp_flag(1, 1, "R10");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            nchk++; nerr++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule